// File: doc/BRIEF.md
# Pipelined CORDIC Sine and Cosine Generator

This block produces the sine and the cosine of a signed fixed-point angle. It uses only shift-and-add CORDIC rotations: no multiplier and no table of sine values. A new angle can be presented on every clock cycle. Each result appears a fixed number of cycles later, and a valid flag that travels alongside the data marks it.

Any angle in [-pi, pi] is accepted. Angles beyond plus or minus pi/2 are first moved by half a turn, which brings them into the range where the rotation iterations converge. A sign flag follows the sample down the pipeline and negates both results in the last stage. The starting vector is loaded with the reciprocal of the CORDIC gain, so the results need no scaling at the end. Every iteration is a registered stage, and the iteration count sets the latency, which is 12 cycles by default.

Top module: `sincos_cordic_pipe`

## Requirements
- R1: An angle accepted with `angle_vld` = 1 produces its results, with `out_vld` = 1, exactly N_ITER (default 12) rising clock edges later.
- R2: Valid angles on consecutive cycles produce valid results on consecutive cycles, in the same order, with no gap or stall.
- R3: `out_vld` is `angle_vld` delayed by N_ITER cycles. A cycle in which `angle_vld` = 0 never produces `out_vld` = 1, whatever value `angle_in` carries.
- R4: `angle_in` is two's complement with 14 fractional bits (radians times 16384), and legal values lie in [-51472, 51472]. `sin_out` and `cos_out` are two's complement with 16 fractional bits, so 1.0 reads 65536.
- R5: For angles with magnitude up to pi/2, each output differs from the true sine or cosine of the quantized input angle by no more than 1.1e-3.
- R6: For angles with magnitude above pi/2, the half-turn fold followed by negation of both outputs gives the correct signs, within the same 1.1e-3 bound.
- R7: The boundary angles plus and minus pi, plus and minus pi/2, the values one step either side of pi/2, zero and plus or minus one LSB all meet the 1.1e-3 bound.
- R8: The reset is synchronous and active high. While it is asserted, every pipeline register clears, so `out_vld`, `sin_out` and `cos_out` read 0 afterwards, and samples that were in flight when it arrived never emerge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| angle_in | input | 18 | Angle, signed, 14 fractional bits, in [-pi, pi] |
| angle_vld | input | 1 | Marks `angle_in` as a sample to process |
| sin_out | output | 18 | Sine, signed, 16 fractional bits |
| cos_out | output | 18 | Cosine, signed, 16 fractional bits |
| out_vld | output | 1 | Marks `sin_out` and `cos_out` as a result |

## Verification
The bench targets the fold boundaries. At exactly pi/2 the angle must not fold, and one step above it must fold; at plus and minus pi the angle folds to zero, so a missing output negation shows up as cos = +1 instead of -1 and an inverted fold test as a diverged rotation. A stream with gaps, and invalid cycles carrying nonzero angles, would expose a valid line whose depth differs from the data path, because every valid flag would land on a neighbouring sample's result. A reset pulse in the middle of a stream checks that the samples in flight are dropped rather than released late.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

    // Constants are kept with 30 fractional bits and requantized to the
    // format each module needs.
    localparam int    Q_REF         = 30;
    localparam longint PI_QREF      = 64'd3373259426;
    localparam longint HALF_PI_QREF = 64'd1686629713;
    localparam longint INV_GAIN_QREF = 64'd652032874;

    // Rounded shift from the 30-bit reference format down to frac bits.
    function automatic longint requant(input longint v, input int frac);
        return (v + (longint'(1) <<< (Q_REF - frac - 1))) >>> (Q_REF - frac);
    endfunction

    // atan(2^-i) with 30 fractional bits. The first entries are exact; for
    // larger i the two-term series is already below one LSB of error.
    function automatic longint atan_qref(input int i);
        case (i)
            0: return 64'd843314856;
            1: return 64'd497837829;
            2: return 64'd263043837;
            3: return 64'd133525158;
            4: return 64'd67021687;
            5: return 64'd33543516;
            6: return 64'd16775851;
            7: return 64'd8388437;
            default: begin
                if (i >= Q_REF)
                    return 64'd0;
                else if (3 * i >= Q_REF)
                    return longint'(1) <<< (Q_REF - i);
                else
                    return (longint'(1) <<< (Q_REF - i))
                         - ((longint'(1) <<< (Q_REF - 3 * i)) / 3);
            end
        endcase
    endfunction

endpackage

// File: rtl/sincos_fold.sv
module sincos_fold #(
    parameter int ANG_W   = 18,
    parameter int ZG      = 3,
    parameter int Z_W     = ANG_W + ZG + 1,
    parameter int PI_IN   = 51472,
    parameter int HALF_IN = 25736
) (
    input  logic signed [ANG_W-1:0] angle,
    output logic signed [Z_W-1:0]   z_fold,
    output logic                    flip
);
    localparam logic signed [ANG_W:0] PI_W   = (ANG_W + 1)'(PI_IN);
    localparam logic signed [ANG_W:0] HALF_W = (ANG_W + 1)'(HALF_IN);

    logic signed [ANG_W:0] wide_d;
    logic signed [ANG_W:0] folded_d;

    always_comb begin
        wide_d   = {angle[ANG_W-1], angle};
        folded_d = wide_d;
        flip     = 1'b0;
        if (wide_d > HALF_W) begin
            folded_d = wide_d - PI_W;
            flip     = 1'b1;
        end else if (wide_d < -HALF_W) begin
            folded_d = wide_d + PI_W;
            flip     = 1'b1;
        end
        z_fold = {folded_d, {ZG{1'b0}}};
    end

endmodule

// File: rtl/cordic_rot_stage.sv
module cordic_rot_stage import sincos_pkg::*; #(
    parameter int XY_W  = 21,
    parameter int Z_W   = 22,
    parameter int Z_F   = 17,
    parameter int STAGE = 0,
    parameter bit LAST  = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic signed [XY_W-1:0] x_i,
    input  logic signed [XY_W-1:0] y_i,
    input  logic signed [Z_W-1:0]  z_i,
    input  logic                   flip_i,
    output logic signed [XY_W-1:0] x_o,
    output logic signed [XY_W-1:0] y_o,
    output logic signed [Z_W-1:0]  z_o,
    output logic                   flip_o
);
    localparam logic signed [Z_W-1:0] STEP = Z_W'(requant(atan_qref(STAGE), Z_F));

    typedef struct packed {
        logic [XY_W-1:0] x;
        logic [XY_W-1:0] y;
        logic [Z_W-1:0]  z;
        logic            flip;
    } rot_t;

    rot_t st_d, st_q;

    logic signed [XY_W-1:0] x_sh_d, y_sh_d, x_n_d, y_n_d;
    logic signed [Z_W-1:0]  z_n_d;

    always_comb begin
        x_sh_d = x_i >>> STAGE;
        y_sh_d = y_i >>> STAGE;
        if (!z_i[Z_W-1]) begin
            x_n_d = x_i - y_sh_d;
            y_n_d = y_i + x_sh_d;
            z_n_d = z_i - STEP;
        end else begin
            x_n_d = x_i + y_sh_d;
            y_n_d = y_i - x_sh_d;
            z_n_d = z_i + STEP;
        end
        if (LAST && flip_i) begin
            x_n_d = -x_n_d;
            y_n_d = -y_n_d;
        end
        st_d.x    = x_n_d;
        st_d.y    = y_n_d;
        st_d.z    = z_n_d;
        st_d.flip = flip_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign x_o    = signed'(st_q.x);
    assign y_o    = signed'(st_q.y);
    assign z_o    = signed'(st_q.z);
    assign flip_o = st_q.flip;

endmodule

// File: rtl/valid_delay.sv
module valid_delay #(
    parameter int DEPTH = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic vld_i,
    output logic vld_o
);
    logic [DEPTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = (sh_q << 1) | DEPTH'(vld_i);
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign vld_o = sh_q[DEPTH-1];

    // Checker state: cycles since reset, flags accepted and released.
    logic [31:0] since_q, acc_q, emit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            acc_q   <= '0;
            emit_q  <= '0;
        end else begin
            if (since_q != 32'hFFFF_FFFF) since_q <= since_q + 32'd1;
            if (vld_i) acc_q  <= acc_q + 32'd1;
            if (vld_o) emit_q <= emit_q + 32'd1;
        end
    end

    AST_LAT_FLOOR:  assert property (@(posedge clk) disable iff (rst)
        vld_o |-> (since_q >= 32'(DEPTH)));                          // R1
    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> (acc_q > emit_q));                                 // R3
    AST_FLUSHED:    assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !vld_o);                                      // R8

endmodule

// File: rtl/sincos_cordic_pipe.sv
module sincos_cordic_pipe import sincos_pkg::*; #(
    parameter int ANG_W  = 18,
    parameter int ANG_F  = 14,
    parameter int OUT_W  = 18,
    parameter int OUT_F  = 16,
    parameter int N_ITER = 12,
    parameter int GUARD  = 3,
    parameter int ZG     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ANG_W-1:0] angle_in,
    input  logic             angle_vld,
    output logic [OUT_W-1:0] sin_out,
    output logic [OUT_W-1:0] cos_out,
    output logic             out_vld
);
    localparam int Z_F     = ANG_F + ZG;
    localparam int Z_W     = ANG_W + ZG + 1;
    localparam int XY_W    = OUT_W + GUARD;
    localparam int XY_F    = OUT_F + GUARD;
    localparam int PI_IN   = int'(requant(PI_QREF, ANG_F));
    localparam int HALF_IN = int'(requant(HALF_PI_QREF, ANG_F));
    localparam int HALF_Z  = HALF_IN * (2 ** ZG);
    localparam int ONE_OUT = 2 ** OUT_F;
    localparam int OUT_LIM = ONE_OUT + ONE_OUT / 64;
    localparam logic signed [XY_W-1:0] X_START = XY_W'(requant(INV_GAIN_QREF, XY_F));

    logic signed [XY_W-1:0] x_pipe [N_ITER+1];
    logic signed [XY_W-1:0] y_pipe [N_ITER+1];
    logic signed [Z_W-1:0]  z_pipe [N_ITER+1];
    logic                   flip_pipe [N_ITER+1];

    assign x_pipe[0] = X_START;
    assign y_pipe[0] = '0;

    sincos_fold #(
        .ANG_W  (ANG_W),
        .ZG     (ZG),
        .Z_W    (Z_W),
        .PI_IN  (PI_IN),
        .HALF_IN(HALF_IN)
    ) u_fold (
        .angle (signed'(angle_in)),
        .z_fold(z_pipe[0]),
        .flip  (flip_pipe[0])
    );

    for (genvar s = 0; s < N_ITER; s++) begin : g_stage
        cordic_rot_stage #(
            .XY_W (XY_W),
            .Z_W  (Z_W),
            .Z_F  (Z_F),
            .STAGE(s),
            .LAST (s == N_ITER - 1)
        ) u_rot (
            .clk   (clk),
            .rst   (rst),
            .x_i   (x_pipe[s]),
            .y_i   (y_pipe[s]),
            .z_i   (z_pipe[s]),
            .flip_i(flip_pipe[s]),
            .x_o   (x_pipe[s+1]),
            .y_o   (y_pipe[s+1]),
            .z_o   (z_pipe[s+1]),
            .flip_o(flip_pipe[s+1])
        );
    end

    valid_delay #(.DEPTH(N_ITER)) u_vld (
        .clk  (clk),
        .rst  (rst),
        .vld_i(angle_vld),
        .vld_o(out_vld)
    );

    assign cos_out = x_pipe[N_ITER][GUARD +: OUT_W];
    assign sin_out = y_pipe[N_ITER][GUARD +: OUT_W];

    logic unused_tail;
    assign unused_tail = ^{x_pipe[N_ITER][GUARD-1:0], y_pipe[N_ITER][GUARD-1:0],
                           z_pipe[N_ITER], flip_pipe[N_ITER]};

    AST_ANGLE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        angle_vld |-> ($signed(angle_in) <= PI_IN && $signed(angle_in) >= -PI_IN)); // R4
    AST_FOLD_RANGE:  assert property (@(posedge clk) disable iff (rst)
        (angle_vld && $signed(angle_in) <= PI_IN && $signed(angle_in) >= -PI_IN)
        |-> (z_pipe[0] <= HALF_Z && z_pipe[0] >= -HALF_Z));                   // R6
    AST_OUT_UNIT:    assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ($signed(sin_out) <= OUT_LIM && $signed(sin_out) >= -OUT_LIM
                  && $signed(cos_out) <= OUT_LIM && $signed(cos_out) >= -OUT_LIM)); // R5

endmodule

// File: tb/sim_sincos_cordic_pipe.sv
module sim_sincos_cordic_pipe;
    localparam int  LAT    = 12;
    localparam int  PI_Q   = 51472;
    localparam int  HALF_Q = 25736;
    localparam real TOL    = 1.1e-3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        angle_vld = 1'b0;
    logic [17:0] angle_in = '0;
    logic [17:0] sin_out, cos_out;
    logic        out_vld;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    bit    qv[$];
    int    qa[$];
    bit    qf[$];
    string qt[$];

    always #5 clk = ~clk;

    sincos_cordic_pipe u0 (
        .clk(clk), .rst(rst), .angle_in(angle_in), .angle_vld(angle_vld),
        .sin_out(sin_out), .cos_out(cos_out), .out_vld(out_vld)
    );

    function automatic string zone(input int a);
        return (a > HALF_Q || a < -HALF_Q) ? "R2 R6" : "R2 R5";
    endfunction

    task automatic check_out(input bit v, input int a, input bit fl, input string tag);
        string t;
        real ang, es, ec, gs, gc;
        t = fl ? "R8" : tag;
        checks++;
        if (out_vld !== v) begin
            errors++;
            $display("FAIL %s R1 R3: out_vld=%0b expected %0b (angle %0d)", t, out_vld, v, a);
        end
        if (v && out_vld === 1'b1) begin
            ang = $itor(a) / 16384.0;
            es  = $sin(ang);
            ec  = $cos(ang);
            gs  = $itor($signed(sin_out)) / 65536.0;
            gc  = $itor($signed(cos_out)) / 65536.0;
            checks++;
            if (gs - es > TOL || es - gs > TOL) begin
                errors++;
                $display("FAIL %s R4: sin angle %0d got %f expected %f", t, a, gs, es);
            end
            checks++;
            if (gc - ec > TOL || ec - gc > TOL) begin
                errors++;
                $display("FAIL %s R4: cos angle %0d got %f expected %f", t, a, gc, ec);
            end
        end
    endtask

    task automatic step(input bit v, input int a, input bit r, input string tag);
        @(negedge clk);
        if (qv.size() == LAT)
            check_out(qv.pop_front(), qa.pop_front(), qf.pop_front(), qt.pop_front());
        angle_vld = v;
        angle_in  = 18'(a);
        rst       = r;
        if (r) begin
            foreach (qv[k]) begin
                qv[k] = 1'b0;
                qf[k] = 1'b1;
            end
        end
        qv.push_back(v && !r);
        qa.push_back(a);
        qf.push_back(r);
        qt.push_back(tag);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected end");
            finish_run();
        end
    end

    initial begin
        int corners[10];
        corners = '{PI_Q, -PI_Q, HALF_Q, -HALF_Q, HALF_Q + 1, -HALF_Q - 1, 0, 1, -1, HALF_Q - 1};

        // R8: reset state
        repeat (3) step(1'b1, 1000, 1'b1, "R8");
        @(posedge clk);
        #2;
        checks++;
        if (out_vld !== 1'b0) begin errors++; $display("FAIL R8: out_vld=%0b expected 0", out_vld); end
        checks++;
        if (sin_out !== '0) begin errors++; $display("FAIL R8: sin_out=%0h expected 0", sin_out); end
        checks++;
        if (cos_out !== '0) begin errors++; $display("FAIL R8: cos_out=%0h expected 0", cos_out); end

        // R3: idle after reset, R1: single sample latency
        repeat (3) step(1'b0, 0, 1'b0, "R3");
        step(1'b1, 0, 1'b0, "R1");
        repeat (14) step(1'b0, 20000, 1'b0, "R1");

        // R2, R5, R6: back-to-back sweep over the whole range
        for (int a = -PI_Q; a <= PI_Q; a += 97) step(1'b1, a, 1'b0, zone(a));

        // R7: boundary angles, each followed by an invalid cycle (R3)
        foreach (corners[k]) begin
            step(1'b1, corners[k], 1'b0, "R7");
            step(1'b0, corners[k], 1'b0, "R3");
        end
        foreach (corners[k]) step(1'b1, corners[k], 1'b0, "R7");

        // R3: sparse valid pattern with live data on idle cycles
        for (int k = 0; k < 60; k++) step(k % 3 == 0, k * 1500 - 45000, 1'b0, "R3");

        // R8: reset in the middle of a stream
        for (int k = 0; k < 8; k++) step(1'b1, k * 4000, 1'b0, "R5");
        step(1'b0, 0, 1'b1, "R8");
        for (int k = 0; k < 8; k++) step(1'b1, -k * 6000, 1'b0, "R6");

        repeat (LAT + 3) step(1'b0, 0, 1'b0, "R3");
        done = 1'b1;
        finish_run();
    end

endmodule